// File: doc/BRIEF.md
# Instruction Address Counter with Jump Load

This block holds the instruction address of a five-stage pipelined processor and produces the next one on every clock. On ordinary sequential flow the address is a counter that steps by one. A control transfer does not go through a separate next-address adder. Instead, a computed target is written into the counter through its parallel load port.

The load target comes from a single adder whose two operands are chosen by multiplexers:

- For an absolute jump, the adder sums the supplied absolute target and zero.
- For a taken branch, the adder sums the current address and the sign-extended offset.

The load fires when an equality comparison between two register operands succeeds while the branch control is raised. It also fires whenever the absolute-jump control is raised. A stall freezes the counter. Decode of instructions and pipeline hazard handling belong to the surrounding core.

Top module: `pc_jump_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets the address output to 0, whatever the other inputs are.
- R2: With rst, stall, jump_en low and no taken branch, the address increases by exactly 1 at every rising edge.
- R3: With stall high (and rst low), the address keeps its value across the edge, even when a jump or a taken branch is requested.
- R4: With jump_en high and stall low, the next address equals abs_target.
- R5: With branch_en high, jump_en low and cmp_a equal to cmp_b, the next address equals the current address plus rel_offset. rel_offset is read as a 16-bit two's complement value and sign-extended to the address width.
- R6: With branch_en high but cmp_a different from cmp_b, no load happens and the address increments by 1.
- R7: With branch_en low, equal operands cause no load, and the address increments by 1.
- R8: When jump_en and a taken branch occur together, the absolute target wins and the offset is ignored.
- R9: All address arithmetic wraps modulo 2^19. Incrementing 0x7FFFF gives 0, and a relative branch that passes below 0 wraps to the top of the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the current address |
| cmp_a | input | 32 | First branch comparison operand |
| cmp_b | input | 32 | Second branch comparison operand |
| branch_en | input | 1 | Branch-if-equal control |
| jump_en | input | 1 | Absolute jump control |
| rel_offset | input | 16 | Signed branch displacement |
| abs_target | input | 19 | Absolute jump destination |
| pc | output | 19 | Current instruction address |

## Verification
The bench pits stall against a simultaneous jump and taken branch. A design that let the load bypass the stall would move the address there.

It raises branch control with unequal operands, and lowers branch control with equal operands. This catches a load enable that ignores either the comparator or the branch bit.

It branches backwards with a negative offset, and issues a jump and a branch in the same cycle. These cases expose a missing sign extension and a wrong multiplexer priority.

Finally, it steps across the top of the 19-bit range in both directions. A wrong width or carry would leave the address outside the wrapped value.

// File: rtl/pc_jump_counter.sv
module pc_jump_counter #(
  parameter int ADDR_W = 19,
  parameter int OPND_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [OPND_W-1:0] cmp_a,
  input  logic [OPND_W-1:0] cmp_b,
  input  logic              branch_en,
  input  logic              jump_en,
  input  logic [OFF_W-1:0]  rel_offset,
  input  logic [ADDR_W-1:0] abs_target,
  output logic [ADDR_W-1:0] pc
);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;
  logic              opnd_eq;
  logic              branch_hit;
  logic              load_en;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] add_a;
  logic [ADDR_W-1:0] add_b;
  logic [ADDR_W-1:0] load_val;
  logic [ADDR_W-1:0] pc_inc;

  assign opnd_eq    = (cmp_a == cmp_b);
  assign branch_hit = branch_en & opnd_eq;
  assign load_en    = branch_hit | jump_en;

  assign off_ext  = {{EXT_W{rel_offset[OFF_W-1]}}, rel_offset};
  assign add_a    = jump_en ? abs_target : pc_q;
  assign add_b    = jump_en ? '0 : off_ext;
  assign load_val = add_a + add_b;
  assign pc_inc   = pc_q + STEP;

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else if (!stall)
      pc_q <= load_en ? load_val : pc_inc;
  end

  assign pc = pc_q;
endmodule

// File: rtl/pc_jump_counter_chk.sv
module pc_jump_counter_chk #(
  parameter int ADDR_W = 19,
  parameter int OPND_W = 32,
  parameter int OFF_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic [OPND_W-1:0] cmp_a,
  input logic [OPND_W-1:0] cmp_b,
  input logic              branch_en,
  input logic              jump_en,
  input logic [OFF_W-1:0]  rel_offset,
  input logic [ADDR_W-1:0] abs_target,
  input logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  logic [ADDR_W-1:0] disp;
  logic              eq_hit;
  assign disp   = ADDR_W'($signed(rel_offset));
  assign eq_hit = branch_en && (cmp_a == cmp_b);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> pc == '0);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> pc == $past(pc));

  // R4
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && jump_en) |=> pc == $past(abs_target));

  // R5
  branch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !jump_en && eq_hit) |=> pc == $past(pc) + $past(disp));

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !jump_en && !eq_hit) |=> pc == $past(pc) + ONE);
endmodule

bind pc_jump_counter pc_jump_counter_chk #(
  .ADDR_W(ADDR_W), .OPND_W(OPND_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .branch_en(branch_en), .jump_en(jump_en), .rel_offset(rel_offset),
  .abs_target(abs_target), .pc(pc)
);

// File: tb/pc_jump_counter_tb.sv
`timescale 1ns/1ps
module pc_jump_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] cmp_a = '0;
  logic [31:0] cmp_b = '0;
  logic        branch_en = 1'b0;
  logic        jump_en = 1'b0;
  logic [15:0] rel_offset = '0;
  logic [18:0] abs_target = '0;
  logic [18:0] pc;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pc_jump_counter u_dut (
    .clk(clk), .rst(rst), .stall(stall), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .branch_en(branch_en), .jump_en(jump_en), .rel_offset(rel_offset),
    .abs_target(abs_target), .pc(pc)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [18:0] exp);
    n_chk++;
    if (pc !== exp) begin
      n_bad++;
      $display("FAIL %s: pc=%h expected=%h", req, pc, exp);
    end
  endtask

  task automatic idle();
    stall = 0; branch_en = 0; jump_en = 0; rst = 0;
    cmp_a = 32'h1; cmp_b = 32'h2; rel_offset = '0; abs_target = '0;
  endtask

  task automatic t_reset();
    rst = 1; jump_en = 1; abs_target = 19'h12345; tick();
    chk("R1 reset", 19'h0);
    idle(); tick(); tick();
    rst = 1; tick();
    chk("R1 reset from nonzero", 19'h0);
    idle();
  endtask

  task automatic t_increment();
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk("R2 increment", 19'(i));
    end
  endtask

  task automatic t_stall();
    logic [18:0] held;
    held = pc;
    stall = 1; jump_en = 1; abs_target = 19'h3AAAA;
    branch_en = 1; cmp_a = 32'h7; cmp_b = 32'h7; rel_offset = 16'h0100;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 stall hold", held);
    end
    idle();
  endtask

  task automatic t_jump();
    jump_en = 1; abs_target = 19'h5A5A5; tick();
    chk("R4 jump", 19'h5A5A5);
    abs_target = 19'h00010; tick();
    chk("R4 jump again", 19'h00010);
    idle();
  endtask

  task automatic t_branch_taken();
    branch_en = 1; cmp_a = 32'hDEADBEEF; cmp_b = 32'hDEADBEEF;
    rel_offset = 16'h0020; tick();
    chk("R5 branch positive", 19'h00030);
    rel_offset = 16'hFFFD; tick();
    chk("R5 branch negative", 19'h0002D);
    rel_offset = 16'h8000; tick();
    chk("R5 branch min offset", 19'h0002D - 19'h08000);
    idle();
  endtask

  task automatic t_branch_unequal();
    logic [18:0] base;
    base = pc;
    branch_en = 1; cmp_a = 32'h0000_0001; cmp_b = 32'h8000_0001;
    rel_offset = 16'h0400; tick();
    chk("R6 unequal increments", base + 19'h1);
    idle();
  endtask

  task automatic t_branch_off();
    logic [18:0] base;
    base = pc;
    cmp_a = 32'h55; cmp_b = 32'h55; rel_offset = 16'h0400; tick();
    chk("R7 branch_en low", base + 19'h1);
    idle();
  endtask

  task automatic t_both();
    jump_en = 1; abs_target = 19'h01234;
    branch_en = 1; cmp_a = 32'h9; cmp_b = 32'h9; rel_offset = 16'h0777; tick();
    chk("R8 jump wins", 19'h01234);
    idle();
  endtask

  task automatic t_wrap();
    jump_en = 1; abs_target = 19'h7FFFF; tick();
    idle(); tick();
    chk("R9 increment wraps", 19'h0);
    tick(); tick();
    branch_en = 1; cmp_a = 32'h3; cmp_b = 32'h3; rel_offset = 16'hFFFB; tick();
    chk("R9 branch wraps low", 19'h7FFFD);
    rel_offset = 16'h0010; tick();
    chk("R9 branch wraps high", 19'h0000D);
    idle();
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: pc=%h expected=finish", pc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_increment();
    t_stall();
    t_jump();
    t_branch_taken();
    t_branch_unequal();
    t_branch_off();
    t_both();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule